// File: doc/BRIEF.md
# Cache Snoop Controller with Run-Time Hit Policy

This block watches transactions that other bus masters place on the memory bus and keeps one cache's contents consistent with them. Each snooped transaction is checked against a small direct-mapped array of tags, valid bits, dirty bits and one data word per line. The array has two sides. The processor side fills and reads lines. The snoop side compares and modifies lines. While the snoop side works, the processor side is held off.

What happens on a snooped write depends on a two-bit policy input, and the policy can change between transactions:
- **Compare-and-invalidate:** the line is dropped on a tag match.
- **Compare-and-update:** the bus data is copied into the matching line, and the line stays valid.
- **Blind invalidate:** the indexed line is dropped without reading its tag.

Each policy holds the processor port for its own number of cycles. A write-back mode input turns on snooping of bus reads. In that mode, a read that matches a line the processor has modified raises a flag. Another agent uses that flag to supply the data.

Top module: `snoop_ctrl`

## Requirements
- R1: After reset, every line is invalid, `stall` is low, `cpu_ready` is high, and no strobe or flag is raised.
- R2: A processor write accepted while `cpu_ready` is high does four things to line `addr[5:2]`: it stores tag `addr[15:6]` and the data word, sets valid, and sets the dirty bit to the value of `wb_mode`. `cpu_hit` is high when the line at `cpu_addr[5:2]` is valid and holds tag `cpu_addr[15:6]`. When `cpu_hit` is high, `cpu_rdata` is that line's word.
- R3: Policy 2'b00 (and 2'b11) on a snooped write gives one compare cycle with `stall` high. On a tag hit, a second stalled cycle follows with `inv_stb` high, and the line becomes invalid. On a miss, only the single cycle occurs and the array is unchanged.
- R4: Policy 2'b01 on a snooped write gives one stalled compare cycle. On a hit, a second stalled cycle follows with `upd_stb` high, and the line then holds `snp_wdata` and stays valid. On a miss, only the single cycle occurs.
- R5: Policy 2'b10 on a snooped write gives exactly one stalled cycle with `inv_stb` high. The line at `snp_addr[5:2]` becomes invalid whatever its tag.
- R6: When `wb_mode` is high, a snooped read gives one stalled cycle. In that cycle `dirty_hit` is high exactly when the line is valid, its tag matches, and it is dirty. The array is unchanged.
- R7: When `wb_mode` is low, a snooped read is ignored: no stall and no strobe.
- R8: `cpu_ready` is low in every cycle that `stall` is high. A processor access offered in such a cycle is not performed.
- R9: `policy_sel` and `wb_mode` are sampled only in the cycle a snoop is accepted. Changing them while the snoop is in progress has no effect on it.
- R10: A snoop request presented while `stall` is high is ignored.
- R11: No snooped transaction stalls the processor port for more than two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_valid | input | 1 | A bus transaction is present for snooping |
| snp_write | input | 1 | 1 = bus write, 0 = bus read |
| snp_addr | input | AW | Bus address: tag, index, word offset |
| snp_wdata | input | DW | Bus write data |
| policy_sel | input | 2 | 00/11 invalidate, 01 update, 10 blind invalidate |
| wb_mode | input | 1 | Write-back mode: snoop reads, mark processor writes dirty |
| cpu_valid | input | 1 | Processor access request |
| cpu_write | input | 1 | Processor access is a write |
| cpu_addr | input | AW | Processor address |
| cpu_wdata | input | DW | Processor write data |
| cpu_ready | output | 1 | Processor access accepted this cycle |
| cpu_hit | output | 1 | Processor address hits a valid line |
| cpu_rdata | output | DW | Word of the addressed line |
| stall | output | 1 | Snoop holds the processor port |
| inv_stb | output | 1 | Valid bit of the snooped line is cleared this cycle |
| upd_stb | output | 1 | Data word of the snooped line is written this cycle |
| dirty_hit | output | 1 | Snooped read matched a dirty line |

## Verification
The bench targets the following cases, each with the failure it would expose:
- **Update-policy miss.** A design that skipped the compare would corrupt an unrelated line.
- **Blind invalidate on a non-matching tag.** A design that compared tags would leave the line alive.
- **Policy or mode switched in the middle of a snoop.** A design that read the live inputs would switch action partway through.
- **Second snoop or processor write offered during a stall.** A design without the guard would act on it.
- **Read snoops in both modes, against clean and dirty lines.** These expose a `dirty_hit` raised for clean lines, or read snoops that stall when write-back mode is off.

// File: rtl/snoop_ctrl.sv
module snoop_ctrl #(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int IDXW = 4,
  parameter int OFFW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snp_valid,
  input  logic          snp_write,
  input  logic [AW-1:0] snp_addr,
  input  logic [DW-1:0] snp_wdata,
  input  logic [1:0]    policy_sel,
  input  logic          wb_mode,
  input  logic          cpu_valid,
  input  logic          cpu_write,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic          cpu_hit,
  output logic [DW-1:0] cpu_rdata,
  output logic          stall,
  output logic          inv_stb,
  output logic          upd_stb,
  output logic          dirty_hit
);
  localparam int LINES = 1 << IDXW;
  localparam int TAGW  = AW - IDXW - OFFW;

  typedef enum logic [1:0] {S_IDLE, S_CMP, S_ACT} st_t;

  st_t             st;
  logic [1:0]      pol_q;
  logic            wr_q;
  logic [IDXW-1:0] idx_q;
  logic [TAGW-1:0] tag_q;
  logic [DW-1:0]   data_q;

  logic            vld  [LINES];
  logic            drt  [LINES];
  logic [TAGW-1:0] tags [LINES];
  logic [DW-1:0]   words[LINES];

  logic [IDXW-1:0] cpu_idx;
  logic [TAGW-1:0] cpu_tag;
  logic            accept, snp_hit, cpu_wr;

  assign cpu_idx   = cpu_addr[OFFW +: IDXW];
  assign cpu_tag   = cpu_addr[AW-1 -: TAGW];
  assign stall     = (st != S_IDLE);
  assign cpu_ready = !stall;
  assign cpu_wr    = cpu_valid && cpu_write && cpu_ready;
  assign accept    = !stall && snp_valid && (snp_write || wb_mode);
  assign snp_hit   = vld[idx_q] && (tags[idx_q] == tag_q);
  assign inv_stb   = (st == S_ACT) && (pol_q != 2'b01);
  assign upd_stb   = (st == S_ACT) && (pol_q == 2'b01);
  assign dirty_hit = (st == S_CMP) && !wr_q && snp_hit && drt[idx_q];
  assign cpu_hit   = vld[cpu_idx] && (tags[cpu_idx] == cpu_tag);
  assign cpu_rdata = words[cpu_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      pol_q <= 2'b00;
      wr_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          pol_q <= policy_sel;
          wr_q  <= snp_write;
          st    <= (snp_write && policy_sel == 2'b10) ? S_ACT : S_CMP;
        end
        S_CMP:   st <= (wr_q && snp_hit) ? S_ACT : S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      idx_q  <= snp_addr[OFFW +: IDXW];
      tag_q  <= snp_addr[AW-1 -: TAGW];
      data_q <= snp_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        vld[i] <= 1'b0;
        drt[i] <= 1'b0;
      end
    end else begin
      if (cpu_wr) begin
        vld[cpu_idx] <= 1'b1;
        drt[cpu_idx] <= wb_mode;
      end
      if (inv_stb) vld[idx_q] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (cpu_wr) begin
      tags[cpu_idx]  <= cpu_tag;
      words[cpu_idx] <= cpu_wdata;
    end
    if (upd_stb) words[idx_q] <= data_q;
  end
endmodule

module snoop_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       snp_valid,
  input logic       snp_write,
  input logic [1:0] policy_sel,
  input logic       cpu_ready,
  input logic       stall,
  input logic       inv_stb,
  input logic       upd_stb,
  input logic       dirty_hit
);
  // R8
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !cpu_ready);
  // R5
  blind_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && snp_valid && snp_write && policy_sel == 2'b10) |=> (stall && inv_stb));
  // R11
  max_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && $past(stall)) |=> !stall);
  // R3
  action_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_stb || upd_stb) |=> !stall);
  // R4
  upd_after_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> $past(stall));
  // R6
  dirty_in_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_hit |-> (stall && !inv_stb && !upd_stb));
endmodule

bind snoop_ctrl snoop_ctrl_chk u_chk (.*);

// File: tb/sim_snoop_ctrl.sv
module sim_snoop_ctrl;
  logic        clk = 0, rst_n = 0;
  logic        snp_valid = 0, snp_write = 0, wb_mode = 0;
  logic [15:0] snp_addr = 0, cpu_addr = 0;
  logic [31:0] snp_wdata = 0, cpu_wdata = 0, cpu_rdata;
  logic [1:0]  policy_sel = 0;
  logic        cpu_valid = 0, cpu_write = 0;
  logic        cpu_ready, cpu_hit, stall, inv_stb, upd_stb, dirty_hit;

  always #2.5 clk = ~clk;

  snoop_ctrl u0 (.*);

  typedef struct {bit inv; bit upd; bit dh; int act; int idx; logic [31:0] data;} rec_t;
  rec_t q[$];
  rec_t r;
  bit          m_v[16], m_d[16];
  logic [9:0]  m_t[16];
  logic [31:0] m_w[16];
  int tests = 0, fails = 0;
  string cur_req = "R1";

  function automatic logic [15:0] mk(int t, int i);
    return {t[9:0], i[3:0], 2'b00};
  endfunction

  task automatic chk(string req, string what, logic [31:0] a, logic [31:0] e);
    tests++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, a, e, $time);
    end
  endtask

  function automatic rec_t mkrec(bit inv, bit upd, bit dh, int act, int idx, logic [31:0] d);
    rec_t x;
    x.inv = inv; x.upd = upd; x.dh = dh; x.act = act; x.idx = idx; x.data = d;
    return x;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      for (int i = 0; i < 16; i++) begin m_v[i] = 0; m_d[i] = 0; end
    end else if (q.size() > 0) begin
      r = q.pop_front();
      if (r.act == 1) m_v[r.idx] = 0;
      if (r.act == 2) m_w[r.idx] = r.data;
    end else begin
      if (cpu_valid && cpu_write) begin
        m_v[cpu_addr[5:2]] = 1;
        m_d[cpu_addr[5:2]] = wb_mode;
        m_t[cpu_addr[5:2]] = cpu_addr[15:6];
        m_w[cpu_addr[5:2]] = cpu_wdata;
      end
      if (snp_valid) begin
        int i;
        bit h;
        i = snp_addr[5:2];
        h = m_v[i] && (m_t[i] == snp_addr[15:6]);
        if (snp_write) begin
          if (policy_sel == 2'b10) q.push_back(mkrec(1, 0, 0, 1, i, 0));
          else if (policy_sel == 2'b01) begin
            q.push_back(mkrec(0, 0, 0, 0, i, 0));
            if (h) q.push_back(mkrec(0, 1, 0, 2, i, snp_wdata));
          end else begin
            q.push_back(mkrec(0, 0, 0, 0, i, 0));
            if (h) q.push_back(mkrec(1, 0, 0, 1, i, 0));
          end
        end else if (wb_mode)
          q.push_back(mkrec(0, 0, h && m_d[i], 0, i, 0));
      end
    end
    #2;
    if (rst_n) begin
      bit es, eh;
      rec_t c;
      c = mkrec(0, 0, 0, 0, 0, 0);
      es = (q.size() > 0);
      if (es) c = q[0];
      eh = m_v[cpu_addr[5:2]] && (m_t[cpu_addr[5:2]] == cpu_addr[15:6]);
      chk(cur_req, "stall", 32'(stall), 32'(es));
      chk("R8", "cpu_ready", 32'(cpu_ready), 32'(!es));
      chk(cur_req, "inv_stb", 32'(inv_stb), 32'(c.inv));
      chk(cur_req, "upd_stb", 32'(upd_stb), 32'(c.upd));
      chk("R6", "dirty_hit", 32'(dirty_hit), 32'(c.dh));
      chk("R2", "cpu_hit", 32'(cpu_hit), 32'(eh));
      if (eh) chk("R2", "cpu_rdata", cpu_rdata, m_w[cpu_addr[5:2]]);
    end
  end

  task automatic cpu_w(int t, int i, logic [31:0] d);
    cpu_valid = 1; cpu_write = 1; cpu_addr = mk(t, i); cpu_wdata = d;
    @(negedge clk);
    cpu_valid = 0; cpu_write = 0;
  endtask

  task automatic cpu_r(int t, int i);
    cpu_valid = 1; cpu_write = 0; cpu_addr = mk(t, i);
    @(negedge clk);
    cpu_valid = 0;
  endtask

  task automatic snp(bit w, int t, int i, logic [31:0] d, logic [1:0] p);
    snp_valid = 1; snp_write = w; snp_addr = mk(t, i); snp_wdata = d; policy_sel = p;
    @(negedge clk);
    snp_valid = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    cur_req = "R1";
    chk("R1", "stall after reset", 32'(stall), 0);
    chk("R1", "ready after reset", 32'(cpu_ready), 1);
    for (int i = 0; i < 16; i++) cpu_r(0, i);
    // R2: fill and read
    cur_req = "R2";
    for (int i = 0; i < 8; i++) cpu_w(i + 3, i, 32'hA000_0000 + i);
    for (int i = 0; i < 8; i++) cpu_r(i + 3, i);
    cpu_r(99, 2);
    // R3: invalidate hit, miss, and code 11
    cur_req = "R3";
    snp(1, 4, 1, 32'h1, 2'b00); cpu_r(4, 1);
    snp(1, 50, 2, 32'h2, 2'b00); cpu_r(5, 2);
    snp(1, 8, 5, 32'h3, 2'b11); cpu_r(8, 5);
    // R4: update hit and miss
    cur_req = "R4";
    snp(1, 6, 3, 32'hBEEF_0003, 2'b01); cpu_r(6, 3);
    snp(1, 77, 4, 32'hDEAD_0004, 2'b01); cpu_r(7, 4);
    // R5: blind invalidate, tag mismatch still clears
    cur_req = "R5";
    snp(1, 123, 6, 32'h0, 2'b10); cpu_r(9, 6);
    snp(1, 10, 7, 32'h0, 2'b10); cpu_r(10, 7);
    // R9: policy and mode changed mid-snoop
    cur_req = "R9";
    snp_valid = 1; snp_write = 1; snp_addr = mk(3, 0); snp_wdata = 32'h55; policy_sel = 2'b00;
    @(negedge clk);
    snp_valid = 0; policy_sel = 2'b01; wb_mode = 1;
    repeat (3) @(negedge clk);
    wb_mode = 0;
    cpu_r(3, 0);
    // R10: snoop during stall ignored; R8: cpu write during stall dropped
    cur_req = "R10";
    cpu_w(20, 9, 32'h9999);
    cpu_w(21, 10, 32'hAAAA);
    snp_valid = 1; snp_write = 1; snp_addr = mk(20, 9); snp_wdata = 32'h1234; policy_sel = 2'b01;
    @(negedge clk);
    snp_addr = mk(21, 10); policy_sel = 2'b10;
    cpu_valid = 1; cpu_write = 1; cpu_addr = mk(30, 11); cpu_wdata = 32'h7777;
    @(negedge clk);
    snp_valid = 0; cpu_valid = 0; cpu_write = 0;
    repeat (3) @(negedge clk);
    cpu_r(20, 9); cpu_r(21, 10); cpu_r(30, 11);
    // R7: read snoop with write-back off
    cur_req = "R7";
    snp(0, 21, 10, 0, 2'b00);
    // R6: read snoops in write-back mode
    cur_req = "R6";
    wb_mode = 1;
    cpu_w(40, 12, 32'hC0DE);
    snp(0, 40, 12, 0, 2'b00);
    snp(0, 41, 12, 0, 2'b01);
    snp(0, 21, 10, 0, 2'b10);
    snp(1, 40, 12, 32'hF00D, 2'b01);
    snp(0, 40, 12, 0, 2'b00);
    // R3 cpu write in snoop accept cycle
    cur_req = "R3";
    cpu_valid = 1; cpu_write = 1; cpu_addr = mk(60, 13); cpu_wdata = 32'h6060;
    snp_valid = 1; snp_write = 1; snp_addr = mk(60, 13); policy_sel = 2'b00;
    @(negedge clk);
    cpu_valid = 0; cpu_write = 0; snp_valid = 0;
    repeat (3) @(negedge clk);
    wb_mode = 0;
    // R11: back-to-back snoops never stall over two cycles
    cur_req = "R11";
    cpu_w(70, 14, 32'h70);
    snp_valid = 1; snp_write = 1; snp_addr = mk(70, 14); policy_sel = 2'b00;
    repeat (6) @(negedge clk);
    snp_valid = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 16; i++) cpu_r(i + 3, i);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule